// File: doc/BRIEF.md
# SECDED Memory ECC Unit

This block protects a 32-bit memory longword with seven check bits. On the write side it turns the outgoing data word into its seven check bits, which are stored beside the data. On the read side it recomputes the check bits from the returned data. It XORs them with the stored check bits to form a syndrome, and it sorts that syndrome into one of four outcomes. The outcomes are: no error, a failed check bit, a failed data bit that is repaired by inversion, or damage that cannot be repaired.

The check matrix is fixed. Each data bit has a seven-bit column code of odd weight, at least three. Check bit i is the even parity of every data bit whose column code has bit i set. A single failed data bit therefore produces exactly its own column code as the syndrome. A failed check bit produces a weight-one syndrome. Two failures produce a nonzero syndrome of even weight.

The write path is purely combinational. The read result is registered and appears one clock after a cycle with `rd_valid` high. The result carries the repaired data, the raw syndrome and two flags that an error logging or interrupt path can consume.

Top module: `ecc_secded_unit`

## Requirements
- R1: `wr_check[i]` is the XOR of every `wr_data[j]` whose column code has bit i set. The column codes for data bits 0..31 are, in decimal: 88, 25, 26, 91, 28, 93, 94, 31, 104, 41, 42, 107, 44, 109, 110, 47, 112, 49, 50, 115, 52, 117, 118, 55, 56, 121, 122, 59, 124, 61, 62, 127. Bit i of a code is its weight-2^i bit.
- R2: One clock after a cycle with `rd_valid` high, `out_syndrome` equals `rd_check` XOR the check bits that R1 gives for `rd_data`. Bit i of the syndrome belongs to check bit i.
- R3: A zero syndrome gives `out_data` equal to `rd_data`, with `out_single` and `out_double` both low.
- R4: A syndrome with exactly one bit set, 2^k, marks check bit k as failed. `out_data` equals `rd_data`, `out_single` is high and `out_double` is low.
- R5: A syndrome equal to the column code of data bit j gives `out_data` equal to `rd_data` with bit j inverted. `out_single` is high and `out_double` is low.
- R6: A nonzero syndrome of even weight raises `out_double`, keeps `out_single` low, and gives `out_data` equal to the uncorrected `rd_data`.
- R7: A syndrome of odd weight, three or more, that matches no column code raises `out_double`, keeps `out_single` low, and gives `out_data` equal to the uncorrected `rd_data`.
- R8: `out_valid` equals `rd_valid` delayed by one clock. While `rd_valid` is low, `out_data`, `out_syndrome`, `out_single` and `out_double` keep their values.
- R9: While `rst_n` is low, `out_valid`, `out_data`, `out_syndrome`, `out_single` and `out_double` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 32 | Data word about to be written |
| wr_check | output | 7 | Check bits for `wr_data` (combinational) |
| rd_valid | input | 1 | `rd_data` and `rd_check` hold a word read from memory |
| rd_data | input | 32 | Data bits as read |
| rd_check | input | 7 | Check bits as read |
| out_valid | output | 1 | A read result is presented |
| out_data | output | 32 | Read data, repaired when a single data bit failed |
| out_syndrome | output | 7 | Stored check bits XOR recomputed check bits |
| out_single | output | 1 | One bit (data or check) failed and was handled |
| out_double | output | 1 | Uncorrectable error |

## Verification
Encoding and decoding run side by side: the write path must produce correct check bits in the same cycle that a read word is being classified and captured. The bench therefore drives a fresh `wr_data` and a read word together on most cycles, so the two paths are loaded at once. It compares `wr_check` and the registered read result against its own model on every clock. The read words are built by injecting chosen failures into correctly encoded words: every single check bit, every single data bit, pairs of bits, and a triple of check bits whose syndrome lies outside the code table. Idle cycles change the read inputs to show that the result holds.

// File: rtl/ecc_secded_pkg.sv
package ecc_secded_pkg;

  localparam int DATA_W = 32;
  localparam int CHK_W  = 7;

  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [1:0] {
    SYN_CLEAN  = 2'd0,
    SYN_CHKBIT = 2'd1,
    SYN_DATA   = 2'd2,
    SYN_UNCORR = 2'd3
  } syn_kind_e;

  // Column of the check matrix for each data bit (odd weight, at least three).
  function automatic chk_t column_code(input int unsigned bit_idx);
    chk_t c;
    case (bit_idx)
      0:  c = 7'd88;   1:  c = 7'd25;   2:  c = 7'd26;   3:  c = 7'd91;
      4:  c = 7'd28;   5:  c = 7'd93;   6:  c = 7'd94;   7:  c = 7'd31;
      8:  c = 7'd104;  9:  c = 7'd41;   10: c = 7'd42;   11: c = 7'd107;
      12: c = 7'd44;   13: c = 7'd109;  14: c = 7'd110;  15: c = 7'd47;
      16: c = 7'd112;  17: c = 7'd49;   18: c = 7'd50;   19: c = 7'd115;
      20: c = 7'd52;   21: c = 7'd117;  22: c = 7'd118;  23: c = 7'd55;
      24: c = 7'd56;   25: c = 7'd121;  26: c = 7'd122;  27: c = 7'd59;
      28: c = 7'd124;  29: c = 7'd61;   30: c = 7'd62;   31: c = 7'd127;
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ecc_check_gen.sv
// Check-bit generator: check bit i is the parity of the data bits whose
// column code has bit i set (R1).
module ecc_check_gen
  import ecc_secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] check
);

  for (genvar gi = 0; gi < CW; gi++) begin : g_row
    logic [DW-1:0] row_mask;
    always_comb begin
      for (int j = 0; j < DW; j++) begin
        row_mask[j] = column_code(j)[gi];
      end
    end
    assign check[gi] = ^(data & row_mask);
  end

endmodule

// File: rtl/ecc_syndrome_class.sv
// Sorts a syndrome into its outcome and builds the data-bit repair mask.
module ecc_syndrome_class
  import ecc_secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [CW-1:0] syndrome,
  output syn_kind_e     kind,
  output logic [DW-1:0] flip_mask
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic is_zero;
  logic is_pow2;
  logic is_odd;
  logic hit;

  for (genvar gj = 0; gj < DW; gj++) begin : g_col
    assign flip_mask[gj] = (syndrome == column_code(gj));
  end

  assign is_zero = (syndrome == '0);
  assign is_pow2 = !is_zero && ((syndrome & (syndrome - ONE)) == '0);
  assign is_odd  = ^syndrome;
  assign hit     = |flip_mask;

  always_comb begin
    if (is_zero) begin
      kind = SYN_CLEAN;
    end else if (is_pow2) begin
      kind = SYN_CHKBIT;
    end else if (is_odd && hit) begin
      kind = SYN_DATA;
    end else begin
      kind = SYN_UNCORR;
    end
  end

endmodule

// File: rtl/ecc_secded_unit.sv
module ecc_secded_unit
  import ecc_secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] wr_check,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic [CW-1:0] rd_check,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_syndrome,
  output logic          out_single,
  output logic          out_double
);

  logic [CW-1:0] rd_recalc;
  logic [CW-1:0] syn_now;
  syn_kind_e     kind_now;
  logic [DW-1:0] flip_now;

  // next-state values
  logic [DW-1:0] data_d;
  logic          single_d;
  logic          double_d;

  // registers
  logic          valid_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] syn_q;
  logic          single_q;
  logic          double_q;

  ecc_check_gen #(.DW(DW), .CW(CW)) i_wr_gen (
    .data  (wr_data),
    .check (wr_check)
  );

  ecc_check_gen #(.DW(DW), .CW(CW)) i_rd_gen (
    .data  (rd_data),
    .check (rd_recalc)
  );

  assign syn_now = rd_check ^ rd_recalc;

  ecc_syndrome_class #(.DW(DW), .CW(CW)) i_class (
    .syndrome  (syn_now),
    .kind      (kind_now),
    .flip_mask (flip_now)
  );

  always_comb begin
    data_d   = rd_data;
    single_d = 1'b0;
    double_d = 1'b0;
    case (kind_now)
      SYN_CHKBIT: single_d = 1'b1;
      SYN_DATA: begin
        data_d   = rd_data ^ flip_now;
        single_d = 1'b1;
      end
      SYN_UNCORR: double_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      syn_q    <= '0;
      single_q <= 1'b0;
      double_q <= 1'b0;
    end else if (rd_valid) begin
      data_q   <= data_d;
      syn_q    <= syn_now;
      single_q <= single_d;
      double_q <= double_d;
    end
  end

  assign out_valid    = valid_q;
  assign out_data     = data_q;
  assign out_syndrome = syn_q;
  assign out_single   = single_q;
  assign out_double   = double_q;

endmodule

// File: rtl/ecc_secded_unit_chk.sv
module ecc_secded_unit_chk #(
  parameter int DW = 32,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic [CW-1:0] out_syndrome,
  input logic          out_single,
  input logic          out_double
);

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_single && out_double));

  assert_clean_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_syndrome == '0) |-> (!out_single && !out_double));

  assert_chkbit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $countones(out_syndrome) == 1) |-> (out_single && !out_double));

  assert_even_double_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_syndrome != '0 && !(^out_syndrome)) |-> (out_double && !out_single));

  assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(rd_valid)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> ($stable(out_data) && $stable(out_syndrome)
                   && $stable(out_single) && $stable(out_double)));

endmodule

bind ecc_secded_unit ecc_secded_unit_chk #(.DW(DW), .CW(CW)) i_ecc_secded_unit_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_valid     (rd_valid),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_syndrome (out_syndrome),
  .out_single   (out_single),
  .out_double   (out_double)
);

// File: tb/test_ecc_secded_unit.sv
`timescale 1ns/1ps
module test_ecc_secded_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wr_data = '0;
  logic [6:0]  wr_check;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic [6:0]  rd_check = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [6:0]  out_syndrome;
  logic        out_single;
  logic        out_double;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ecc_secded_unit i_ecc_secded_unit (
    .clk(clk), .rst_n(rst_n),
    .wr_data(wr_data), .wr_check(wr_check),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_check(rd_check),
    .out_valid(out_valid), .out_data(out_data), .out_syndrome(out_syndrome),
    .out_single(out_single), .out_double(out_double)
  );

  int unsigned codes [32] = '{88, 25, 26, 91, 28, 93, 94, 31, 104, 41, 42, 107,
                              44, 109, 110, 47, 112, 49, 50, 115, 52, 117, 118, 55,
                              56, 121, 122, 59, 124, 61, 62, 127};

  function automatic logic [6:0] model_check(input logic [31:0] d);
    logic [6:0] c = '0;
    for (int j = 0; j < 32; j++)
      if (d[j]) c = c ^ 7'(codes[j]);
    return c;
  endfunction

  function automatic int weight(input logic [6:0] s);
    int w = 0;
    for (int i = 0; i < 7; i++) w += int'(s[i]);
    return w;
  endfunction

  function automatic int lookup(input logic [6:0] s);
    for (int j = 0; j < 32; j++)
      if (7'(codes[j]) == s) return j;
    return -1;
  endfunction

  // reference model state
  logic        m_valid = 0;
  logic [31:0] m_data = '0;
  logic [6:0]  m_syn = '0;
  logic        m_single = 0;
  logic        m_double = 0;
  string       m_tag = "R9";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_data = '0; m_syn = '0; m_single = 0; m_double = 0; m_tag = "R9";
    end else begin
      m_valid = rd_valid;
      if (rd_valid) begin
        logic [6:0] s;
        int w, idx;
        s = rd_check ^ model_check(rd_data);
        w = weight(s);
        idx = lookup(s);
        m_syn = s;
        m_data = rd_data;
        m_single = 0;
        m_double = 0;
        if (w == 0) begin
          m_tag = "R3";
        end else if (w == 1) begin
          m_tag = "R4"; m_single = 1;
        end else if (w % 2 == 0) begin
          m_tag = "R6"; m_double = 1;
        end else if (idx >= 0) begin
          m_tag = "R5"; m_single = 1; m_data[idx] = ~m_data[idx];
        end else begin
          m_tag = "R7"; m_double = 1;
        end
      end else begin
        m_tag = "R8";
      end
    end
  end

  task automatic check_val(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check_val("R1", "wr_check", 32'(wr_check), 32'(model_check(wr_data)));
      check_val(rst_n ? "R8" : "R9", "out_valid", 32'(out_valid), 32'(m_valid));
      check_val(m_tag, "out_data", out_data, m_data);
      check_val("R2", "out_syndrome", 32'(out_syndrome), 32'(m_syn));
      check_val(m_tag, "out_single", 32'(out_single), 32'(m_single));
      check_val(m_tag, "out_double", 32'(out_double), 32'(m_double));
    end
  end

  task automatic drive(input logic v, input logic [31:0] d, input logic [6:0] c,
                       input logic [31:0] w);
    @(negedge clk);
    #0.5;
    rd_valid = v; rd_data = d; rd_check = c; wr_data = w;
  endtask

  task automatic read_with(input logic [31:0] d, input logic [31:0] dflip,
                           input logic [6:0] cflip);
    drive(1'b1, d ^ dflip, model_check(d) ^ cflip, $urandom);
  endtask

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(13));
    repeat (3) @(negedge clk);
    // explicit reset check R9
    check_val("R9", "out_data in reset", out_data, 32'h0);
    check_val("R9", "out_valid in reset", 32'(out_valid), 32'h0);
    @(negedge clk); #0.5; rst_n = 1'b1;
    // R3: clean words
    read_with(32'h0, '0, '0);
    read_with(32'hFFFF_FFFF, '0, '0);
    read_with(32'hDEAD_BEEF, '0, '0);
    // R4: each check bit failed
    for (int k = 0; k < 7; k++) read_with($urandom, '0, 7'(1 << k));
    // R5: each data bit failed
    for (int j = 0; j < 32; j++) read_with($urandom, 32'(1) << j, '0);
    // R6: double failures (data+data, data+check, check+check)
    read_with(32'h1234_5678, 32'h0000_0003, '0);
    read_with(32'hA5A5_5A5A, 32'h8000_0000, 7'h01);
    read_with(32'h0F0F_F0F0, '0, 7'h41);
    // R7: odd-weight syndrome outside the table (check bits 0..2 -> 7)
    read_with(32'h7777_0000, '0, 7'h07);
    read_with(32'h0000_0001, '0, 7'h07);
    // R8: idle cycles with moving read inputs must hold the result
    for (int n = 0; n < 4; n++) drive(1'b0, $urandom, 7'($urandom), $urandom);
    read_with(32'hCAFE_F00D, 32'h0001_0000, '0);
    drive(1'b0, $urandom, 7'($urandom), $urandom);
    // mixed traffic with concurrent writes
    for (int n = 0; n < 300; n++) begin
      int sel = $urandom_range(0, 5);
      case (sel)
        0: read_with($urandom, '0, '0);
        1: read_with($urandom, '0, 7'(1 << $urandom_range(0, 6)));
        2: read_with($urandom, 32'(1) << $urandom_range(0, 31), '0);
        3: read_with($urandom, 32'(3) << $urandom_range(0, 30), '0);
        4: drive(1'b1, $urandom, 7'($urandom), $urandom);
        default: drive(1'b0, $urandom, 7'($urandom), $urandom);
      endcase
    end
    // reset in the middle, then recover
    @(negedge clk); #0.5; rst_n = 1'b0; rd_valid = 1'b0;
    @(negedge clk);
    check_val("R9", "out_syndrome after reset", 32'(out_syndrome), 32'h0);
    #0.5; rst_n = 1'b1;
    read_with(32'h5555_AAAA, 32'h0000_0100, '0);
    drive(1'b0, '0, '0, '0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule